// File: doc/BRIEF.md
# Real-Time Counter and Watchdog With a Shared Prescaler

This block holds an 8-bit free-running event counter and a watchdog timer that take turns using one 8-bit prescaler. A single select input decides which timer the prescaler serves: it picks both which tick stream feeds the prescaler and which timer receives the divided output. The timer that does not get the prescaler counts its raw tick stream directly. A 3-bit rate field chooses the divide ratio.

The core can load the counter, or add an 8-bit value to it as part of a return-with-add operation. A load, a watchdog-clear command and a sleep command each clear the prescaler, but only when it currently serves the timer that event concerns. When the counter rolls over on an increment it raises a one-cycle pulse for the interrupt logic. The watchdog reports expiry with a pulse and keeps two status flags: a timeout flag and a power-down flag.

Top module: `rtc_wdt_timer`

## Requirements
- R1: After synchronous reset the counter reads 00h, both pulses are low, the timeout flag (to_flag) and power-down flag (pd_flag) read 1, and the prescaler and watchdog count are cleared.
- R2: With psel=0 the prescaler counts cnt_tick and the counter advances once every 2^(rate+1) ticks counted from the last prescaler clear.
- R3: With psel=1 the counter advances on every cnt_tick, and the watchdog advances once every 2^rate wdt_tick pulses counted from the last prescaler clear (rate=0 means every pulse).
- R4: With psel=0 the watchdog advances on every wdt_tick.
- R5: cnt_wr loads cnt_wdata into the counter at the next edge; when psel=0 it also clears the prescaler.
- R6: cnt_add adds add_val to the counter modulo 256 at the next edge; if cnt_wr is also high, the load wins.
- R7: A load or add in the same cycle as a counter increment takes priority and the increment is lost, with no rollover pulse.
- R8: An increment from FFh yields 00h and a one-cycle cnt_ovf pulse in the same cycle that the counter reads 00h.
- R9: wdt_clr clears the watchdog count and sets to_flag and pd_flag to 1; it clears the prescaler only when psel=1.
- R10: sleep sets pd_flag to 0; it clears the prescaler only when psel=1.
- R11: When the watchdog, at count FFh, receives one more advance, it wraps to 0, pulses wdt_timeout for one cycle and sets to_flag to 0.
- R12: If wdt_clr and sleep arrive together, pd_flag becomes 0 and to_flag becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Prescaler owner: 0 counter, 1 watchdog |
| rate | input | 3 | Divide-ratio selector |
| cnt_tick | input | 1 | Counter tick stream (one pulse per event) |
| wdt_tick | input | 1 | Watchdog oscillator tick stream |
| cnt_wr | input | 1 | Load the counter |
| cnt_wdata | input | 8 | Value to load |
| cnt_add | input | 1 | Add to the counter (return-with-add) |
| add_val | input | 8 | Value to add |
| wdt_clr | input | 1 | Watchdog-clear command |
| sleep | input | 1 | Sleep command |
| cnt_q | output | 8 | Counter value |
| cnt_ovf | output | 1 | Counter rollover pulse |
| wdt_timeout | output | 1 | Watchdog expiry pulse |
| to_flag | output | 1 | Timeout flag, 0 after an expiry |
| pd_flag | output | 1 | Power-down flag, 0 after sleep |

## Verification
The collisions that matter are a core load or add landing in the same cycle as a counter increment, and a prescaler-clearing command landing on the same edge as the tick that would have produced a divided event. Directed cases put a load on top of an increment at FFh and check that the loaded value appears with no rollover pulse. They also issue clears just before a divided event is due and count the ticks until the next advance. Random stimulus then drives all inputs, including changes of owner, and a bench model compares every output on every cycle.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
  localparam int PRE_W  = 8;
  localparam int RATE_W = 3;

  // Low-order mask of k ones within a PRE_W-bit prescaler.
  function automatic logic [PRE_W-1:0] low_mask(input logic [RATE_W:0] k);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (i < int'(k));
    return m;
  endfunction
endpackage

// File: rtl/rtcw_prescaler.sv
module rtcw_prescaler
  import rtcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wdt,
  input  logic [RATE_W-1:0] rate,
  input  logic              cnt_tick,
  input  logic              wdt_tick,
  input  logic              clr,
  output logic              cnt_evt,
  output logic              wdt_evt
);
  logic [PRE_W-1:0] pre_q;
  logic [RATE_W:0]  k;
  logic [PRE_W-1:0] msk;
  logic             tick_sel;
  logic             div_evt;

  always_comb begin
    k        = sel_wdt ? {1'b0, rate} : ({1'b0, rate} + 1'b1);
    msk      = low_mask(k);
    tick_sel = sel_wdt ? wdt_tick : cnt_tick;
    div_evt  = tick_sel && ((pre_q & msk) == msk);
    cnt_evt  = sel_wdt ? cnt_tick : div_evt;
    wdt_evt  = sel_wdt ? div_evt  : wdt_tick;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)    pre_q <= '0;
    else if (tick_sel) pre_q <= pre_q + 1'b1;
  end

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pre_q == '0)); // R5
endmodule

// File: rtl/rtcw_counter.sv
module rtcw_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             add,
  input  logic [CNT_W-1:0] add_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (wr)       cnt_q <= wdata;
      else if (add) cnt_q <= cnt_q + add_val;
      else if (inc) begin
        cnt_q <= cnt_q + 1'b1;
        ovf_q <= (cnt_q == TOP);
      end
    end
  end

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cnt_q == $past(wdata))); // R5
  AST_CNT_ADD: assert property (@(posedge clk) disable iff (rst)
    (add && !wr) |=> (cnt_q == CNT_W'($past(cnt_q) + $past(add_val)))); // R6
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (cnt_q == '0)); // R8
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> !ovf_q); // R8
  AST_OVF_NEEDS_INC: assert property (@(posedge clk) disable iff (rst)
    (wr || add) |=> !ovf_q); // R7
endmodule

// File: rtl/rtcw_watchdog.sv
module rtcw_watchdog #(
  parameter int WD_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic clr_cmd,
  input  logic sleep_cmd,
  output logic tmo_q,
  output logic to_q,
  output logic pd_q
);
  localparam logic [WD_W-1:0] TOP = '1;
  logic [WD_W-1:0] wd_q;
  logic            expire;

  assign expire = adv && !clr_cmd && (wd_q == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q  <= '0;
      tmo_q <= 1'b0;
      to_q  <= 1'b1;
      pd_q  <= 1'b1;
    end else begin
      tmo_q <= expire;
      if (clr_cmd)  wd_q <= '0;
      else if (adv) wd_q <= wd_q + 1'b1;
      if (clr_cmd)     to_q <= 1'b1;
      else if (expire) to_q <= 1'b0;
      if (sleep_cmd)    pd_q <= 1'b0;
      else if (clr_cmd) pd_q <= 1'b1;
    end
  end

  AST_TMO_FLAG: assert property (@(posedge clk) disable iff (rst)
    tmo_q |-> !to_q); // R11
  AST_CLR_TO: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> (to_q && !tmo_q)); // R9
  AST_SLEEP_PD: assert property (@(posedge clk) disable iff (rst)
    sleep_cmd |=> !pd_q); // R10
  AST_CLR_PD: assert property (@(posedge clk) disable iff (rst)
    (clr_cmd && !sleep_cmd) |=> pd_q); // R12
endmodule

// File: rtl/rtc_wdt_timer.sv
module rtc_wdt_timer
  import rtcw_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int WD_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic [RATE_W-1:0] rate,
  input  logic              cnt_tick,
  input  logic              wdt_tick,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              cnt_add,
  input  logic [CNT_W-1:0]  add_val,
  input  logic              wdt_clr,
  input  logic              sleep,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              cnt_ovf,
  output logic              wdt_timeout,
  output logic              to_flag,
  output logic              pd_flag
);
  logic pre_clr;
  logic cnt_evt;
  logic wdt_evt;

  // Each clearing event counts only for the timer that owns the prescaler.
  assign pre_clr = (cnt_wr && !psel) || ((wdt_clr || sleep) && psel);

  rtcw_prescaler i_pre (
    .clk      (clk),
    .rst      (rst),
    .sel_wdt  (psel),
    .rate     (rate),
    .cnt_tick (cnt_tick),
    .wdt_tick (wdt_tick),
    .clr      (pre_clr),
    .cnt_evt  (cnt_evt),
    .wdt_evt  (wdt_evt)
  );

  rtcw_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (cnt_evt),
    .wr      (cnt_wr),
    .wdata   (cnt_wdata),
    .add     (cnt_add),
    .add_val (add_val),
    .cnt_q   (cnt_q),
    .ovf_q   (cnt_ovf)
  );

  rtcw_watchdog #(.WD_W(WD_W)) i_wd (
    .clk       (clk),
    .rst       (rst),
    .adv       (wdt_evt),
    .clr_cmd   (wdt_clr),
    .sleep_cmd (sleep),
    .tmo_q     (wdt_timeout),
    .to_q      (to_flag),
    .pd_q      (pd_flag)
  );

  AST_RESET_FLAGS: assert property (@(posedge clk)
    rst |=> (to_flag && pd_flag && !cnt_ovf && !wdt_timeout && cnt_q == '0)); // R1
endmodule

// File: tb/test_rtc_wdt_timer.sv
module test_rtc_wdt_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       psel = 1'b0;
  logic [2:0] rate = '0;
  logic       cnt_tick = 1'b0, wdt_tick = 1'b0, cnt_wr = 1'b0, cnt_add = 1'b0;
  logic [7:0] cnt_wdata = '0, add_val = '0;
  logic       wdt_clr = 1'b0, sleep = 1'b0;
  logic [7:0] cnt_q;
  logic       cnt_ovf, wdt_timeout, to_flag, pd_flag;

  int total = 0, bad = 0, cycles = 0;

  // reference state
  logic [7:0] m_pre, m_cnt, m_wd;
  logic       m_ovf, m_tmo, m_to, m_pd;

  rtc_wdt_timer i_rtc_wdt_timer (
    .clk(clk), .rst(rst), .psel(psel), .rate(rate),
    .cnt_tick(cnt_tick), .wdt_tick(wdt_tick),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_add(cnt_add), .add_val(add_val),
    .wdt_clr(wdt_clr), .sleep(sleep),
    .cnt_q(cnt_q), .cnt_ovf(cnt_ovf), .wdt_timeout(wdt_timeout),
    .to_flag(to_flag), .pd_flag(pd_flag)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic logic [7:0] mask_of(input int k);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i < k);
    return m;
  endfunction

  task automatic model_reset();
    m_pre = 0; m_cnt = 0; m_wd = 0; m_ovf = 0; m_tmo = 0; m_to = 1; m_pd = 1;
  endtask

  task automatic compare_all();
    check("R2 R3 R6 counter value", cnt_q, m_cnt);
    check("R8 rollover pulse", {7'd0, cnt_ovf}, {7'd0, m_ovf});
    check("R11 expiry pulse", {7'd0, wdt_timeout}, {7'd0, m_tmo});
    check("R9 timeout flag", {7'd0, to_flag}, {7'd0, m_to});
    check("R10 power-down flag", {7'd0, pd_flag}, {7'd0, m_pd});
  endtask

  // Called at a falling edge; drives one cycle and checks at the next falling edge.
  task automatic step(input bit ct, input bit wt, input bit wr, input logic [7:0] wv,
                      input bit ad, input logic [7:0] av, input bit wc, input bit sl);
    logic [7:0] m; logic ts, pe, clr, ci, wi;
    cnt_tick = ct; wdt_tick = wt; cnt_wr = wr; cnt_wdata = wv;
    cnt_add = ad; add_val = av; wdt_clr = wc; sleep = sl;
    m   = mask_of(psel ? int'(rate) : int'(rate) + 1);
    ts  = psel ? wt : ct;
    pe  = ts && ((m_pre & m) == m);
    clr = (wr && !psel) || ((wc || sl) && psel);
    ci  = psel ? ct : pe;
    wi  = psel ? pe : wt;
    @(posedge clk);
    m_ovf = !wr && !ad && ci && (m_cnt == 8'hFF);
    m_tmo = !wc && wi && (m_wd == 8'hFF);
    m_pre = clr ? 8'h00 : (ts ? m_pre + 8'd1 : m_pre);
    m_cnt = wr ? wv : (ad ? m_cnt + av : (ci ? m_cnt + 8'd1 : m_cnt));
    m_wd  = wc ? 8'h00 : (wi ? m_wd + 8'd1 : m_wd);
    m_to  = wc ? 1'b1 : (m_tmo ? 1'b0 : m_to);
    m_pd  = sl ? 1'b0 : (wc ? 1'b1 : m_pd);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); step(0,0,0,8'h00,0,8'h00,0,0); endtask
  task automatic ctick(); step(1,0,0,8'h00,0,8'h00,0,0); endtask
  task automatic wtick(); step(0,1,0,8'h00,0,8'h00,0,0); endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cnt_tick = 0; wdt_tick = 0; cnt_wr = 0; cnt_add = 0; wdt_clr = 0; sleep = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      bad++; total++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    check("R1 counter after reset", cnt_q, 8'h00);
    check("R1 rollover low", {7'd0, cnt_ovf}, 8'h00);
    check("R1 expiry low", {7'd0, wdt_timeout}, 8'h00);
    check("R1 timeout flag high", {7'd0, to_flag}, 8'h01);
    check("R1 power-down flag high", {7'd0, pd_flag}, 8'h01);

    // R2: psel=0, rate=1 -> divide by 4
    psel = 0; rate = 3'd1;
    repeat (3) ctick();
    check("R2 no advance before 4 ticks", cnt_q, 8'h00);
    ctick();
    check("R2 advance on 4th tick", cnt_q, 8'h01);

    // R5: load clears prescaler when owned by counter
    repeat (2) ctick();
    step(0,0,1,8'h10,0,8'h00,0,0);
    check("R5 load value", cnt_q, 8'h10);
    repeat (3) ctick();
    check("R5 prescaler restarted by load", cnt_q, 8'h10);
    ctick();
    check("R5 advance 4 ticks after load", cnt_q, 8'h11);

    // R9: watchdog clear leaves counter-owned prescaler alone
    repeat (2) ctick();
    step(0,0,0,8'h00,0,8'h00,1,0);
    repeat (2) ctick();
    check("R9 prescaler kept through wdt_clr", cnt_q, 8'h12);
    check("R9 flags set", {6'd0, to_flag, pd_flag}, 8'h03);

    // R10: sleep leaves counter-owned prescaler alone, clears pd
    repeat (2) ctick();
    step(0,0,0,8'h00,0,8'h00,0,1);
    check("R10 pd cleared by sleep", {7'd0, pd_flag}, 8'h00);
    repeat (2) ctick();
    check("R10 prescaler kept through sleep", cnt_q, 8'h13);

    // R3 counter direct, R8 rollover, R7 priority
    psel = 1;
    step(0,0,1,8'hFE,0,8'h00,0,0);
    ctick();
    check("R3 direct increment", cnt_q, 8'hFF);
    ctick();
    check("R8 wrap to zero", cnt_q, 8'h00);
    check("R8 rollover pulse", {7'd0, cnt_ovf}, 8'h01);
    idle();
    check("R8 pulse lasts one cycle", {7'd0, cnt_ovf}, 8'h00);
    step(0,0,1,8'hFF,0,8'h00,0,0);
    step(1,0,1,8'h40,0,8'h00,0,0);
    check("R7 load beats increment", cnt_q, 8'h40);
    check("R7 no pulse when load wins", {7'd0, cnt_ovf}, 8'h00);

    // R6 add and load-over-add
    step(0,0,0,8'h00,1,8'hC5,0,0);
    check("R6 add wraps modulo 256", cnt_q, 8'h05);
    step(1,0,0,8'h00,1,8'h0A,0,0);
    check("R7 add beats increment", cnt_q, 8'h0F);
    step(0,0,1,8'h22,1,8'h11,0,0);
    check("R6 load beats add", cnt_q, 8'h22);

    // R4 and R11: psel=0, watchdog counts raw ticks
    psel = 0;
    step(0,0,0,8'h00,0,8'h00,1,0);
    repeat (255) wtick();
    check("R4 no expiry after 255 ticks", {7'd0, wdt_timeout}, 8'h00);
    check("R11 to flag still high", {7'd0, to_flag}, 8'h01);
    wtick();
    check("R11 expiry pulse", {7'd0, wdt_timeout}, 8'h01);
    check("R11 to flag low", {7'd0, to_flag}, 8'h00);
    idle();
    check("R11 pulse one cycle", {7'd0, wdt_timeout}, 8'h00);

    // R3 watchdog prescaled, R10 sleep clears watchdog-owned prescaler
    psel = 1; rate = 3'd2;
    step(0,0,0,8'h00,0,8'h00,1,0);
    repeat (1022) wtick();
    check("R3 no expiry yet", {7'd0, wdt_timeout}, 8'h00);
    step(0,0,0,8'h00,0,8'h00,0,1);
    repeat (3) wtick();
    check("R10 sleep restarted prescaler", {7'd0, wdt_timeout}, 8'h00);
    wtick();
    check("R3 expiry after 256 divided events", {7'd0, wdt_timeout}, 8'h01);

    // R12 both commands together
    step(0,0,0,8'h00,0,8'h00,1,1);
    check("R12 pd low", {7'd0, pd_flag}, 8'h00);
    check("R12 to high", {7'd0, to_flag}, 8'h01);

    // constrained random traffic
    for (int n = 0; n < 6000; n++) begin
      if (($urandom % 64) == 0) psel = $urandom % 2;
      if (($urandom % 128) == 0) rate = 3'($urandom);
      step(($urandom % 2) == 1, ($urandom % 2) == 1,
           ($urandom % 40) == 0, 8'($urandom),
           ($urandom % 40) == 0, 8'($urandom),
           ($urandom % 60) == 0, ($urandom % 60) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule